// File: doc/BRIEF.md
# Memory-Mapped Halt Port with Retire-Boundary Stop

This block ends a simulation or bring-up run cleanly. Software stores an exit code to one reserved bus address. The port latches the full data word as the exit code and raises a one-cycle halt pulse. A small core sequencer takes that pulse as its external halt input and holds the request. It stops only when the instruction in flight has retired. After that it never fetches again until reset.

The sequencer is a stub of a multi-cycle core. It walks fetch, execute and writeback, and it reports the word it retired. It does not decode the instruction. A jump-to-self, encoding 0x0000006f, is therefore an ordinary endless loop and cannot end the run. A compiler may emit that encoding in code that must keep running, such as an idle loop. Only the explicit store can stop the core.

Top module: `mmio_stop_unit`

## Requirements
- R1: While rstN is low, and at the first sample after reset is released: haltCode is 0, haltStrobe is 0, halted is 0 and coreState is FETCH.
- R2: A write to HALT_ADDR is accepted when busValid, busWrite and a nonzero busBe are all set and the core is not halted. An accepted write loads all 32 bits of busWdata into haltCode, whatever the byte-strobe pattern. The new value is visible from the next clock edge.
- R3: Each accepted write raises haltStrobe for exactly one cycle, starting at the edge that captures the code.
- R4: The following leave haltCode unchanged and raise no strobe: a write to any other address (including addresses that differ only in bit 31 or by ±4), a write with busBe = 0, and any read.
- R5: A read (busValid high, busWrite low) of HALT_ADDR returns haltCode on busRdata in the same cycle. Every other access returns 0.
- R6: coreState uses the encoding FETCH=0, EXEC=1, WB=2, HALTED=3, and steps FETCH→EXEC→WB→FETCH. fetchEn is high only in FETCH. retire is high only in WB, and then retiredInstr shows the instrWord sampled in the preceding FETCH.
- R7: No instruction word causes a halt. A stream of 0x0000006f keeps fetching and retiring.
- R8: A halt request is latched when haltStrobe rises and is held. The core enters HALTED only at the edge that ends a WB cycle, never in the middle of an instruction.
- R9: A strobe that is high during a WB cycle is not lost: that instruction retires and halted is high from the next edge.
- R10: HALTED lasts until reset. While halted, fetchEn and retire stay low.
- R11: While halted, writes to HALT_ADDR are ignored: the first exit code is kept and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busBe | input | DATA_W/8 | Byte strobes |
| busRdata | output | DATA_W | Read data, combinational |
| instrWord | input | DATA_W | Instruction word presented at fetch |
| haltCode | output | DATA_W | Captured exit code |
| haltStrobe | output | 1 | One-cycle halt pulse |
| coreState | output | 2 | Sequencer state |
| fetchEn | output | 1 | Fetch in progress |
| retire | output | 1 | Instruction retiring this cycle |
| retiredInstr | output | DATA_W | Word being retired |
| halted | output | 1 | Core stopped |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit data word and the halt address 0x10001ff8. With the full 32-bit compare, the bench can write near-miss addresses: the two neighbouring words and an alias that differs only in bit 31. It can also write the halt address with a single byte strobe and check that the whole word is still captured. The bench places a halt write in the execute cycle so that the strobe coincides with writeback. This exercises the path in which the request must be acted on without ever having been latched first.

// File: rtl/stop_pkg.sv
package stop_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_EXEC   = 2'd1,
    ST_WB     = 2'd2,
    ST_HALTED = 2'd3
  } coreSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCode;
    logic pulse;
    logic readSel;
  } dpCtrl_t;
endpackage

// File: rtl/stop_datapath.sv
module stop_datapath
  import stop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] codeQ,
  output logic              strobeQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ   <= '0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= ctl.pulse;
      if (ctl.loadCode) codeQ <= wdata;
    end
  end

  assign rdata = ctl.readSel ? codeQ : '0;
endmodule

// File: rtl/stop_control.sv
module stop_control
  import stop_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h1000_1ff8,
  localparam int             BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] instrWord,
  input  logic              externalHalt,
  output dpCtrl_t           ctl,
  output coreSt_e           state,
  output logic [DATA_W-1:0] irQ
);
  logic addrHit;
  logic pendReq;

  assign addrHit      = busValid && (busAddr == HALT_ADDR);
  assign ctl.loadCode = addrHit && busWrite && (|busBe) && (state != ST_HALTED);
  assign ctl.pulse    = ctl.loadCode;
  assign ctl.readSel  = addrHit && !busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_FETCH;
      pendReq <= 1'b0;
      irQ     <= '0;
    end else begin
      if (externalHalt) pendReq <= 1'b1;
      unique case (state)
        ST_FETCH: begin
          irQ   <= instrWord;
          state <= ST_EXEC;
        end
        ST_EXEC:  state <= ST_WB;
        ST_WB:    state <= (pendReq || externalHalt) ? ST_HALTED : ST_FETCH;
        default:  state <= ST_HALTED;
      endcase
    end
  end
endmodule

// File: rtl/mmio_stop_unit.sv
module mmio_stop_unit
  import stop_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h1000_1ff8,
  localparam int             BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BE_W-1:0]   busBe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] instrWord,
  output logic [DATA_W-1:0] haltCode,
  output logic              haltStrobe,
  output logic [1:0]        coreState,
  output logic              fetchEn,
  output logic              retire,
  output logic [DATA_W-1:0] retiredInstr,
  output logic              halted
);
  dpCtrl_t ctl;
  coreSt_e st;
  logic [DATA_W-1:0] irQ;

  stop_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALT_ADDR(HALT_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .instrWord(instrWord),
    .externalHalt(haltStrobe), .ctl(ctl), .state(st), .irQ(irQ)
  );

  stop_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(busWdata),
    .rdata(busRdata), .codeQ(haltCode), .strobeQ(haltStrobe)
  );

  assign coreState    = st;
  assign fetchEn      = (st == ST_FETCH);
  assign retire       = (st == ST_WB);
  assign halted       = (st == ST_HALTED);
  assign retiredInstr = irQ;
endmodule

// File: rtl/stop_checker.sv
module stop_checker #(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h1000_1ff8,
  localparam int             BE_W      = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BE_W-1:0]   busBe,
  input logic [DATA_W-1:0] haltCode,
  input logic              haltStrobe,
  input logic [1:0]        coreState,
  input logic              fetchEn,
  input logic              retire,
  input logic              halted
);
  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    haltStrobe |-> $past(busValid && busWrite && (busAddr == HALT_ADDR) && (busBe != '0)));

  assert_other_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && (busAddr != HALT_ADDR)) |=> !haltStrobe);

  assert_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coreState == 2'd0) |=> (coreState == 2'd1));

  assert_halt_from_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> ($past(coreState) == 2'd2));

  assert_strobe_in_wb_R9: assert property (@(posedge clk) disable iff (!rstN)
    (haltStrobe && retire) |=> halted);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  assert_quiet_when_halted_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!fetchEn && !retire));

  assert_code_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> ($stable(haltCode) && !haltStrobe));
endmodule

bind mmio_stop_unit stop_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALT_ADDR(HALT_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busBe(busBe), .haltCode(haltCode), .haltStrobe(haltStrobe), .coreState(coreState),
  .fetchEn(fetchEn), .retire(retire), .halted(halted)
);

// File: tb/sim_mmio_stop_unit.sv
module sim_mmio_stop_unit;
  localparam logic [31:0] HADDR = 32'h1000_1ff8;
  localparam logic [31:0] JSELF = 32'h0000_006f;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0, instrWord = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busRdata, haltCode, retiredInstr;
  logic haltStrobe, fetchEn, retire, halted;
  logic [1:0] coreState;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mmio_stop_unit u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata), .instrWord(instrWord),
    .haltCode(haltCode), .haltStrobe(haltStrobe), .coreState(coreState), .fetchEn(fetchEn),
    .retire(retire), .retiredInstr(retiredInstr), .halted(halted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  task automatic idleBus();
    busValid = 0; busWrite = 0; busAddr = '0; busWdata = '0; busBe = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; idleBus();
    repeat (3) @(negedge clk);
    check("R1 code in reset", haltCode, 0);
    check("R1 strobe in reset", {31'd0, haltStrobe}, 0);
    rstN = 1;
    check("R1 state", {30'd0, coreState}, 0);
    check("R1 halted", {31'd0, halted}, 0);
  endtask

  // wr, addr, data, be, expected rdata ; none of these may change code or strobe
  localparam int NV = 6;
  localparam logic [100:0] VEC [NV] = '{
    {1'b1, 32'h1000_1ff4, 32'hAAAA_5555, 4'hF, 32'h0},
    {1'b1, 32'h1000_1ffc, 32'h1234_5678, 4'hF, 32'h0},
    {1'b1, 32'h9000_1ff8, 32'h0BAD_F00D, 4'hF, 32'h0},
    {1'b1, HADDR,         32'hCAFE_0001, 4'h0, 32'h0},
    {1'b0, HADDR,         32'h0,         4'h0, 32'h0},
    {1'b0, 32'h1000_1ff0, 32'h0,         4'h0, 32'h0}
  };

  initial begin
    doReset();

    // table walk: R4 / R5
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busValid = 1; busWrite = VEC[i][100]; busAddr = VEC[i][99:68];
      busWdata = VEC[i][67:36]; busBe = VEC[i][35:32];
      #1 check("R5 rdata", busRdata, VEC[i][31:0]);
      @(negedge clk);
      idleBus();
      check("R4 code unchanged", haltCode, 0);
      check("R4 no strobe", {31'd0, haltStrobe}, 0);
    end

    // R6/R7: jump-to-self stream keeps running
    begin
      int fetches = 0, retires = 0, orderBad = 0;
      logic [1:0] prev;
      instrWord = JSELF;
      @(negedge clk); prev = coreState;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (fetchEn) fetches++;
        if (retire) begin
          retires++;
          if (retiredInstr !== JSELF) orderBad++;
        end
        if (coreState != ((prev == 2'd2) ? 2'd0 : prev + 2'd1)) orderBad++;
        if ((fetchEn !== (coreState == 2'd0)) || (retire !== (coreState == 2'd2))) orderBad++;
        prev = coreState;
      end
      check("R6 order and retired word", orderBad, 0);
      check("R7 not halted by self-jump", {31'd0, halted}, 0);
      check("R7 fetches continue", {31'd0, fetches >= 9}, 1);
      check("R7 retires continue", {31'd0, retires >= 9}, 1);
    end

    // R2/R3/R8: halt write with code 1, single byte strobe
    begin
      logic [1:0] prev;
      int waitC = 0;
      @(negedge clk);
      busValid = 1; busWrite = 1; busAddr = HADDR; busWdata = 32'h1; busBe = 4'b0001;
      @(negedge clk);
      idleBus();
      check("R2 code captured", haltCode, 32'h1);
      check("R3 strobe high", {31'd0, haltStrobe}, 1);
      prev = coreState;
      @(negedge clk);
      check("R3 strobe one cycle", {31'd0, haltStrobe}, 0);
      while (!halted && waitC < 6) begin
        prev = coreState; waitC++;
        @(negedge clk);
      end
      check("R8 halted", {31'd0, halted}, 1);
      check("R8 entered from WB", {30'd0, prev}, 2);
      check("R8 latency", {31'd0, waitC <= 3}, 1);
    end

    // R10/R11: post-halt behaviour
    begin
      int fetches = 0, strobes = 0;
      @(negedge clk);
      busValid = 1; busWrite = 1; busAddr = HADDR; busWdata = 32'h77; busBe = 4'hF;
      @(negedge clk);
      idleBus();
      if (haltStrobe) strobes++;
      check("R11 code preserved", haltCode, 32'h1);
      busValid = 1; busWrite = 0; busAddr = HADDR;
      #1 check("R5 read halt code", busRdata, 32'h1);
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        idleBus();
        if (fetchEn || retire) fetches++;
        if (haltStrobe) strobes++;
      end
      check("R10 no fetch after halt", fetches, 0);
      check("R10 still halted", {31'd0, halted}, 1);
      check("R11 no strobe when halted", strobes, 0);
    end

    // R9: strobe coincides with WB; full-word capture with one byte strobe (R2)
    doReset();
    check("R1 code cleared", haltCode, 0);
    instrWord = 32'h0000_0013;
    begin
      int w = 0;
      while (coreState != 2'd1 && w < 5) begin @(negedge clk); w++; end
    end
    busValid = 1; busWrite = 1; busAddr = HADDR; busWdata = 32'hDEAD_BEEF; busBe = 4'b1000;
    @(negedge clk);
    idleBus();
    check("R9 in WB with strobe", {30'd0, coreState}, 2);
    check("R9 strobe during WB", {31'd0, haltStrobe}, 1);
    check("R2 full word", haltCode, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R9 halted next edge", {31'd0, halted}, 1);

    finishRun();
  end
endmodule